// File: doc/BRIEF.md
# Superscalar Decode Stage with Group Skid Buffer

This block sits between fetch and rename in a superscalar pipeline. Each cycle fetch may offer a group of up to `DW` instruction slots with a valid count. For every slot the group carries a sequence number, a source-register count, a control-flow bit, a predicted-taken bit and a squashed flag. The stage drops squashed slots and packs the survivors in their original order into a registered output group for rename. Each forwarded instruction that reads no source register is flagged ready to issue. A forwarded instruction that was predicted taken but is not a control instruction raises an error pulse.

When rename, execute or commit asserts stall, the stage stops forwarding. Every non-empty group that arrives from then on is stored whole in a small FIFO of groups. Once all three stalls are low in the same cycle, the stage drains the stored groups one per cycle, ahead of any new fetch traffic. A full buffer is reported back to fetch as a stall. A squash from commit overrides everything else. It empties the buffer, suppresses output for that cycle and returns the stage to normal running.

Top module: `dec_stage`

## Requirements
- R1: While reset is held and right after it, `state_o` is 0 (running), `rn_cnt_o` is 0, every output slot field is 0, and `fe_stall_o` and `mispred_o` are low.
- R2: In running state with all stalls low, a fetch group with nonzero `fe_cnt_i` appears on the rename outputs one clock later. Its count is the number of unsquashed slots among input slots 0 to `fe_cnt_i`-1, and output slots at or above that count read as zero.
- R3: An input slot with its squashed flag set is skipped. The remaining slots keep their relative order and occupy output slots 0, 1, 2 and up without gaps.
- R4: For each forwarded slot, `rn_ready_o` is 1 exactly when its source-register count is zero.
- R5: `mispred_o` is high in the cycle a group is presented to rename if any forwarded slot in it has predicted-taken set and control clear. Squashed slots never raise it.
- R6: State encoding on `state_o` is 0 running, 1 blocked, 2 unblocking. A stall seen in running moves the stage to blocked. That cycle's fetch group is stored if its count is nonzero, and the output count becomes 0. No output is produced while blocked.
- R7: Blocked persists while any of the three stall inputs is high. It moves to unblocking only in a cycle where all three are low. Non-empty fetch groups arriving while blocked are stored.
- R8: In unblocking with all stalls low, the oldest stored group is processed as in R2 to R5 and removed, and a non-empty fetch group of that cycle is appended. The stage returns to running when the buffer is empty after the cycle. Any stall in unblocking returns the stage to blocked with no output.
- R9: `squash_i` takes priority over everything. The next cycle shows count 0, state running and an empty buffer. The fetch group of that cycle is discarded.
- R10: `fe_stall_o` is high exactly when the buffer holds `SKID_DEPTH` groups. A group offered while full, in a cycle that removes nothing, is discarded.
- R11: In running state with all stalls low and `fe_cnt_i` = 0, the next output count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| squash_i | input | 1 | Flush request from commit |
| stall_rename_i | input | 1 | Stall from rename |
| stall_exec_i | input | 1 | Stall from execute |
| stall_commit_i | input | 1 | Stall from commit |
| fe_cnt_i | input | CNT_W | Number of valid fetch slots, 0..DW |
| fe_squashed_i | input | DW | Per-slot squashed flag |
| fe_pred_i | input | DW | Per-slot predicted-taken bit |
| fe_ctrl_i | input | DW | Per-slot control-instruction bit |
| fe_src_i | input | DW*SRC_W | Per-slot source-register count |
| fe_seq_i | input | DW*SEQ_W | Per-slot sequence number |
| fe_stall_o | output | 1 | Buffer full, fetch must hold |
| rn_cnt_o | output | CNT_W | Number of valid rename slots |
| rn_seq_o | output | DW*SEQ_W | Packed sequence numbers |
| rn_src_o | output | DW*SRC_W | Packed source-register counts |
| rn_ctrl_o | output | DW | Packed control bits |
| rn_pred_o | output | DW | Packed predicted-taken bits |
| rn_ready_o | output | DW | Packed can-issue flags |
| mispred_o | output | 1 | Predicted-taken non-control instruction forwarded |
| state_o | output | 2 | Stage status |

## Verification
The bench uses the package widths (four slots, two-bit source counts, eight-bit sequence numbers) and a skid depth of two. With a depth of two, the buffer fills after only two stalled groups. This lets short stall bursts reach the full condition, the drop of a group offered while full, and the simultaneous pop and push at the full boundary. Four slots give enough room for mixed squash patterns, where gaps in front of, between and behind survivors all exercise repacking within each group.

// File: rtl/dec_pkg.sv
package dec_pkg;
    localparam int DW    = 4;
    localparam int SEQ_W = 8;
    localparam int SRC_W = 2;
    localparam int CNT_W = $clog2(DW + 1);
    localparam int IDX_W = $clog2(DW);

    typedef struct packed {
        logic             squashed;
        logic             pred_taken;
        logic             is_ctrl;
        logic [SRC_W-1:0] src_cnt;
        logic [SEQ_W-1:0] seq;
    } slot_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        slot_t [DW-1:0]   slot;
    } group_t;

    typedef struct packed {
        logic             pred_taken;
        logic             is_ctrl;
        logic             can_issue;
        logic [SRC_W-1:0] src_cnt;
        logic [SEQ_W-1:0] seq;
    } uop_t;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_BLOCKED = 2'd1,
        ST_UNBLOCK = 2'd2
    } state_e;
endpackage

// File: rtl/dec_skid_fifo.sv
module dec_skid_fifo
    import dec_pkg::*;
#(
    parameter  int DEPTH = 2,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic             pop,
    input  group_t           wr_grp,
    output group_t           head,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);
    group_t           mem [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [LVL_W-1:0] lvl_q;
    logic             do_pop, do_push;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (lvl_q == '0);
    assign full    = (lvl_q == LVL_W'(DEPTH));
    assign level   = lvl_q;
    assign head    = mem[rd_q];
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);

    always_ff @(posedge clk) begin
        if (do_push && !clear) mem[wr_q] <= wr_grp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rd_q  <= '0;
            wr_q  <= '0;
            lvl_q <= '0;
        end else begin
            if (do_push) wr_q <= wrap_inc(wr_q);
            if (do_pop)  rd_q <= wrap_inc(rd_q);
            lvl_q <= lvl_q + LVL_W'(do_push) - LVL_W'(do_pop);
        end
    end
endmodule

// File: rtl/dec_repack.sv
module dec_repack
    import dec_pkg::*;
(
    input  group_t           grp,
    output uop_t [DW-1:0]    uops,
    output logic [CNT_W-1:0] cnt,
    output logic             err
);
    logic [CNT_W-1:0] wr;

    always_comb begin
        uops = '0;
        err  = 1'b0;
        wr   = '0;
        for (int i = 0; i < DW; i++) begin
            if (CNT_W'(i) < grp.cnt && !grp.slot[i].squashed) begin
                uops[wr[IDX_W-1:0]].seq        = grp.slot[i].seq;
                uops[wr[IDX_W-1:0]].src_cnt    = grp.slot[i].src_cnt;
                uops[wr[IDX_W-1:0]].is_ctrl    = grp.slot[i].is_ctrl;
                uops[wr[IDX_W-1:0]].pred_taken = grp.slot[i].pred_taken;
                uops[wr[IDX_W-1:0]].can_issue  = (grp.slot[i].src_cnt == '0);
                if (grp.slot[i].pred_taken && !grp.slot[i].is_ctrl) err = 1'b1;
                wr = wr + 1'b1;
            end
        end
        cnt = wr;
    end
endmodule

// File: rtl/dec_stage.sv
module dec_stage
    import dec_pkg::*;
#(
    parameter  int SKID_DEPTH = 2,
    localparam int LVL_W      = $clog2(SKID_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  squash_i,
    input  logic                  stall_rename_i,
    input  logic                  stall_exec_i,
    input  logic                  stall_commit_i,
    input  logic [CNT_W-1:0]      fe_cnt_i,
    input  logic [DW-1:0]         fe_squashed_i,
    input  logic [DW-1:0]         fe_pred_i,
    input  logic [DW-1:0]         fe_ctrl_i,
    input  logic [DW*SRC_W-1:0]   fe_src_i,
    input  logic [DW*SEQ_W-1:0]   fe_seq_i,
    output logic                  fe_stall_o,
    output logic [CNT_W-1:0]      rn_cnt_o,
    output logic [DW*SEQ_W-1:0]   rn_seq_o,
    output logic [DW*SRC_W-1:0]   rn_src_o,
    output logic [DW-1:0]         rn_ctrl_o,
    output logic [DW-1:0]         rn_pred_o,
    output logic [DW-1:0]         rn_ready_o,
    output logic                  mispred_o,
    output logic [1:0]            state_o
);
    typedef struct packed {
        state_e           st;
        logic [CNT_W-1:0] cnt;
        uop_t [DW-1:0]    uops;
        logic             err;
    } regs_t;

    regs_t            r_d, r_q;
    group_t           fe_grp, skid_head, rp_src;
    uop_t [DW-1:0]    rp_uops;
    logic [CNT_W-1:0] rp_cnt;
    logic             rp_err;
    logic [LVL_W-1:0] skid_lvl;
    logic             skid_full, skid_empty;
    logic             push, pop, clr, take, push_ok, any_stall, fe_nz;

    always_comb begin
        fe_grp.cnt = fe_cnt_i;
        for (int i = 0; i < DW; i++) begin
            fe_grp.slot[i].squashed   = fe_squashed_i[i];
            fe_grp.slot[i].pred_taken = fe_pred_i[i];
            fe_grp.slot[i].is_ctrl    = fe_ctrl_i[i];
            fe_grp.slot[i].src_cnt    = fe_src_i[i*SRC_W +: SRC_W];
            fe_grp.slot[i].seq        = fe_seq_i[i*SEQ_W +: SEQ_W];
        end
    end

    assign any_stall = stall_rename_i | stall_exec_i | stall_commit_i;
    assign fe_nz     = (fe_cnt_i != '0);
    assign rp_src    = (r_q.st == ST_UNBLOCK) ? skid_head : fe_grp;

    dec_repack i_repack (
        .grp  (rp_src),
        .uops (rp_uops),
        .cnt  (rp_cnt),
        .err  (rp_err)
    );

    dec_skid_fifo #(.DEPTH(SKID_DEPTH)) i_skid (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clr),
        .push   (push),
        .pop    (pop),
        .wr_grp (fe_grp),
        .head   (skid_head),
        .level  (skid_lvl),
        .full   (skid_full),
        .empty  (skid_empty)
    );

    always_comb begin
        r_d      = r_q;
        r_d.cnt  = '0;
        r_d.uops = '0;
        r_d.err  = 1'b0;
        push     = 1'b0;
        pop      = 1'b0;
        clr      = 1'b0;
        take     = 1'b0;
        push_ok  = 1'b0;
        if (squash_i) begin
            clr    = 1'b1;
            r_d.st = ST_RUN;
        end else begin
            unique case (r_q.st)
                ST_RUN: begin
                    if (any_stall) begin
                        r_d.st = ST_BLOCKED;
                        push   = fe_nz;
                    end else begin
                        take = fe_nz;
                    end
                end
                ST_BLOCKED: begin
                    push = fe_nz;
                    if (!any_stall) r_d.st = ST_UNBLOCK;
                end
                ST_UNBLOCK: begin
                    push = fe_nz;
                    if (any_stall) begin
                        r_d.st = ST_BLOCKED;
                    end else begin
                        pop     = !skid_empty;
                        take    = !skid_empty;
                        push_ok = push && (!skid_full || pop);
                        if (skid_lvl - LVL_W'(pop) + LVL_W'(push_ok) == '0)
                            r_d.st = ST_RUN;
                    end
                end
                default: r_d.st = ST_RUN;
            endcase
        end
        if (take) begin
            r_d.cnt  = rp_cnt;
            r_d.uops = rp_uops;
            r_d.err  = rp_err;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_RUN;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        for (int i = 0; i < DW; i++) begin
            rn_seq_o[i*SEQ_W +: SEQ_W] = r_q.uops[i].seq;
            rn_src_o[i*SRC_W +: SRC_W] = r_q.uops[i].src_cnt;
            rn_ctrl_o[i]  = r_q.uops[i].is_ctrl;
            rn_pred_o[i]  = r_q.uops[i].pred_taken;
            rn_ready_o[i] = r_q.uops[i].can_issue;
        end
    end

    assign rn_cnt_o   = r_q.cnt;
    assign mispred_o  = r_q.err;
    assign state_o    = r_q.st;
    assign fe_stall_o = skid_full;
endmodule

module dec_stage_chk
    import dec_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             squash_i,
    input logic             stall_rename_i,
    input logic             stall_exec_i,
    input logic             stall_commit_i,
    input logic [CNT_W-1:0] fe_cnt_i,
    input logic [CNT_W-1:0] rn_cnt_o,
    input logic             mispred_o,
    input logic             fe_stall_o,
    input logic [1:0]       state_o
);
    logic stl;
    assign stl = stall_rename_i | stall_exec_i | stall_commit_i;

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        rn_cnt_o <= CNT_W'(DW)); // R2
    AST_SQUASH_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        squash_i |=> (rn_cnt_o == '0 && state_o == 2'd0 && !fe_stall_o)); // R9
    AST_BLOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1) |-> (rn_cnt_o == '0 && !mispred_o)); // R6
    AST_RUN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!squash_i && state_o == 2'd0 && stl) |=> (state_o == 2'd1)); // R6
    AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!squash_i && state_o == 2'd1 && stl) |=> (state_o == 2'd1)); // R7
    AST_BLOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!squash_i && state_o == 2'd1 && !stl) |=> (state_o == 2'd2)); // R7
    AST_RUN_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0) |-> !fe_stall_o); // R10
    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!squash_i && state_o == 2'd0 && !stl && fe_cnt_i == '0) |=> (rn_cnt_o == '0)); // R11
endmodule

bind dec_stage dec_stage_chk i_chk (.*);

// File: tb/test_dec_stage.sv
module test_dec_stage;
    import dec_pkg::*;
    localparam int DEPTH = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic squash_i = 1'b0, stall_rename_i = 1'b0, stall_exec_i = 1'b0, stall_commit_i = 1'b0;
    logic [CNT_W-1:0]    fe_cnt_i = '0;
    logic [DW-1:0]       fe_squashed_i = '0, fe_pred_i = '0, fe_ctrl_i = '0;
    logic [DW*SRC_W-1:0] fe_src_i = '0;
    logic [DW*SEQ_W-1:0] fe_seq_i = '0;
    logic                fe_stall_o, mispred_o;
    logic [CNT_W-1:0]    rn_cnt_o;
    logic [DW*SEQ_W-1:0] rn_seq_o;
    logic [DW*SRC_W-1:0] rn_src_o;
    logic [DW-1:0]       rn_ctrl_o, rn_pred_o, rn_ready_o;
    logic [1:0]          state_o;

    int total = 0, bad = 0;
    int m_st = 0;
    group_t mq[$];
    int e_cnt, e_err, e_stall;
    int e_seq[DW], e_src[DW], e_ctrl[DW], e_pred[DW], e_rdy[DW];
    int seq_ctr = 0;

    always #4 clk = ~clk;

    dec_stage #(.SKID_DEPTH(DEPTH)) i_dec_stage (.*);

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic group_t mk(input int cnt, input int sqm, input int pm, input int cm, input int srcs);
        group_t g = '0;
        g.cnt = CNT_W'(cnt);
        for (int i = 0; i < DW; i++) begin
            g.slot[i].squashed   = sqm[i];
            g.slot[i].pred_taken = pm[i];
            g.slot[i].is_ctrl    = cm[i];
            g.slot[i].src_cnt    = SRC_W'(srcs >> (i*SRC_W));
            g.slot[i].seq        = SEQ_W'(seq_ctr + i);
        end
        seq_ctr += DW;
        return g;
    endfunction

    function automatic void m_clear_out();
        e_cnt = 0; e_err = 0;
        for (int i = 0; i < DW; i++) begin
            e_seq[i] = 0; e_src[i] = 0; e_ctrl[i] = 0; e_pred[i] = 0; e_rdy[i] = 0;
        end
    endfunction

    function automatic void m_forward(input group_t g);
        int k = 0;
        for (int i = 0; i < int'(g.cnt) && i < DW; i++) begin
            if (!g.slot[i].squashed) begin
                e_seq[k]  = int'(g.slot[i].seq);
                e_src[k]  = int'(g.slot[i].src_cnt);
                e_ctrl[k] = int'(g.slot[i].is_ctrl);
                e_pred[k] = int'(g.slot[i].pred_taken);
                e_rdy[k]  = (g.slot[i].src_cnt == 0) ? 1 : 0;
                if (g.slot[i].pred_taken && !g.slot[i].is_ctrl) e_err = 1;
                k++;
            end
        end
        e_cnt = k;
    endfunction

    function automatic void m_push(input group_t g);
        if (g.cnt != 0 && mq.size() < DEPTH) mq.push_back(g);
    endfunction

    function automatic void m_step(input bit sq, input bit [2:0] stl, input group_t g);
        bit any = |stl;
        m_clear_out();
        if (sq) begin
            mq.delete();
            m_st = 0;
        end else if (m_st == 0) begin
            if (any) begin m_st = 1; m_push(g); end
            else if (g.cnt != 0) m_forward(g);
        end else if (m_st == 1) begin
            m_push(g);
            if (!any) m_st = 2;
        end else begin
            if (any) begin
                m_st = 1; m_push(g);
            end else begin
                if (mq.size() > 0) m_forward(mq.pop_front());
                m_push(g);
                if (mq.size() == 0) m_st = 0;
            end
        end
        e_stall = (mq.size() == DEPTH) ? 1 : 0;
    endfunction

    task automatic compare(input string tag);
        chk(tag, "cnt", int'(rn_cnt_o), e_cnt);
        for (int i = 0; i < DW; i++) begin
            chk(tag, "seq",   int'(rn_seq_o[i*SEQ_W +: SEQ_W]), e_seq[i]);
            chk(tag, "src",   int'(rn_src_o[i*SRC_W +: SRC_W]), e_src[i]);
            chk(tag, "ctrl",  int'(rn_ctrl_o[i]), e_ctrl[i]);
            chk(tag, "pred",  int'(rn_pred_o[i]), e_pred[i]);
            chk(tag, "ready", int'(rn_ready_o[i]), e_rdy[i]);
        end
        chk(tag, "mispred", int'(mispred_o), e_err);
        chk(tag, "state", int'(state_o), m_st);
        chk(tag, "fe_stall", int'(fe_stall_o), e_stall);
    endtask

    task automatic step(input string tag, input bit sq, input bit [2:0] stl, input group_t g);
        @(negedge clk);
        squash_i = sq;
        stall_rename_i = stl[0]; stall_exec_i = stl[1]; stall_commit_i = stl[2];
        fe_cnt_i = g.cnt;
        for (int i = 0; i < DW; i++) begin
            fe_squashed_i[i] = g.slot[i].squashed;
            fe_pred_i[i]     = g.slot[i].pred_taken;
            fe_ctrl_i[i]     = g.slot[i].is_ctrl;
            fe_src_i[i*SRC_W +: SRC_W] = g.slot[i].src_cnt;
            fe_seq_i[i*SEQ_W +: SEQ_W] = g.slot[i].seq;
        end
        m_step(sq, stl, g);
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        group_t z = '0;
        repeat (3) @(posedge clk);
        #1;
        m_clear_out(); e_stall = 0; m_st = 0;
        compare("R1");
        @(negedge clk);
        rst_n = 1'b1;
        step("R1", 0, 3'b000, z);
        step("R11", 0, 3'b000, z);
        step("R2", 0, 3'b000, mk(3, 'h0, 'h0, 'h0, 'hff));
        step("R2", 0, 3'b000, mk(4, 'h0, 'h0, 'h0, 'h55));
        step("R3", 0, 3'b000, mk(4, 'b0101, 'h0, 'h0, 'h5a));
        step("R3", 0, 3'b000, mk(4, 'b1111, 'h0, 'h0, 'h00));
        step("R4", 0, 3'b000, mk(4, 'h0, 'h0, 'h0, 'b00110011));
        step("R5", 0, 3'b000, mk(2, 'h0, 'b10, 'b00, 'h0f));
        step("R5", 0, 3'b000, mk(3, 'b001, 'b001, 'b000, 'h0f));
        step("R6", 0, 3'b001, mk(2, 'h0, 'h0, 'h0, 'h1));
        step("R7", 0, 3'b010, mk(3, 'h0, 'b1, 'b0, 'h0));
        step("R10", 0, 3'b100, mk(4, 'h0, 'h0, 'h0, 'h3));
        step("R7", 0, 3'b000, z);
        step("R8", 0, 3'b000, mk(1, 'h0, 'h0, 'h0, 'h2));
        step("R8", 0, 3'b000, z);
        step("R8", 0, 3'b000, z);
        step("R8", 0, 3'b000, mk(2, 'h0, 'h0, 'h0, 'h0));
        step("R6", 0, 3'b001, mk(2, 'h0, 'h0, 'h0, 'h0));
        step("R8", 0, 3'b000, z);
        step("R8", 0, 3'b010, z);
        step("R9", 1, 3'b001, mk(4, 'h0, 'h0, 'h0, 'h0));
        step("R9", 0, 3'b000, z);
        for (int n = 0; n < 4000; n++) begin
            bit sq = ($urandom % 40) == 0;
            bit [2:0] stl;
            for (int b = 0; b < 3; b++) stl[b] = ($urandom % 5) == 0;
            step("R2/R8 random", sq, stl,
                 mk(int'($urandom % (DW + 1)), int'($urandom), int'($urandom),
                    int'($urandom), int'($urandom)));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule